// File: doc/BRIEF.md
# Package Power Limit Governor

The governor chooses a performance-state index once per control tick. It weighs three limits together, and each limit works over its own time scale. The first is a hard ceiling on supply current. The second is a short-term cap on the instantaneous power sample. The third is a long-term cap, checked against an exponentially weighted running average of package power. The average falls during quiet periods, so the budget built up then lets the package run above the sustained level for a while. Under a steady heavy load the average settles near the long-term limit.

A synchronous write port programs the register file. It holds the limits, the averaging window, the enable and clamp bits, a lock bit and a software state request. The output is a state index, from the lowest efficient state up to the highest turbo state. Two more outputs report the limit that applied on the last tick: one live and one sticky. The states from the guaranteed state up to the maximum belong to the hardware alone. A software request is clipped to the guaranteed state.

Top module: `pkg_pwr_gov`

## Requirements
- R1: After synchronous reset the state is 1 (the lowest state), the reason and status outputs are 0 and the running average is 0. The long-term, short-term and current limits reset to all ones, the window to 0, the control bits to 0 and the request to the guaranteed state 8.
- R2: The state changes only in the clock edge that samples `tick_i` high, and by at most one step. With no limit active it moves one step toward its target and holds there. The target is state 15 when the turbo bit is set.
- R3: With the turbo bit (control bit 4) clear, the target is the software request (address 5), clipped to the range 1..8. A state above the target steps down by one per tick.
- R4: A current sample above the current ceiling (address 3) steps the state down by one per tick, to a floor of 1. It sets reason bit 2 and takes priority over both power limits.
- R5: With control bit 1 set, a power sample above the short-term limit (address 2) steps the state down by one per tick, to a floor of 1. It sets reason bit 1 unless the current limit is active.
- R6: On each tick the average is updated as avg += (sample*256 - avg) >>> k, held with 8 fraction bits. The shift k is the window register (address 1). The whole-number part of the updated average is compared with the long-term limit (address 0). When it is greater and control bit 0 is set, reason bit 0 is set and the state steps down. Without a tick the average holds.
- R7: With the clamp bit (control bit 2) clear, the long-term limit on its own never drives the state below 8. With the clamp bit set it may drive the state down to 1.
- R8: A power limit whose enable bit is clear has no effect on the state or the reason.
- R9: Once the lock bit (control bit 3) is written to 1, writes to addresses 0 to 4 are ignored until reset. Writes to the request and status-clear addresses still take effect.
- R10: `status_o` collects every reason bit seen on a tick and keeps it. Writing a mask to address 6 clears the masked bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Control tick; samples are valid while high |
| pwr_i | input | PW | Package power sample |
| icc_i | input | IW | Supply current sample |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register address |
| wr_data_i | input | PW | Register write data |
| pstate_o | output | SW | Selected performance-state index |
| reason_o | output | 3 | One-hot limit applied on the last tick (bit2 current, bit1 short, bit0 long) |
| status_o | output | 3 | Sticky record of reason bits |

## Verification
A tick seen at a rising edge moves the state, the reason and the sticky status at that same edge. Those results are therefore due one clock after the tick is raised. A register write takes effect at the edge that samples it, so it governs the next tick. The bench drives tick, samples and writes on the falling edge and holds the tick for exactly one cycle. It reads every result at the following falling edge, half a cycle after the update. The long-term cases run through several ticks, and their expected averages are worked out from the update formula before each sample point.

// File: rtl/pgov_pkg.sv
package pgov_pkg;

    localparam int unsigned REG_AW = 3;

    typedef enum logic [REG_AW-1:0] {
        A_LT_LIM   = 3'd0,
        A_WIN      = 3'd1,
        A_ST_LIM   = 3'd2,
        A_ICC_MAX  = 3'd3,
        A_CTRL     = 3'd4,
        A_REQ      = 3'd5,
        A_STAT_CLR = 3'd6
    } reg_addr_e;

    // packed: lt_en is bit 0, turbo_en is bit 4
    typedef struct packed {
        logic turbo_en;
        logic lock;
        logic lt_clamp;
        logic st_en;
        logic lt_en;
    } gov_ctrl_t;

    localparam int unsigned CTRL_W = $bits(gov_ctrl_t);

    typedef enum logic [2:0] {
        RSN_NONE = 3'b000,
        RSN_LT   = 3'b001,
        RSN_ST   = 3'b010,
        RSN_CUR  = 3'b100
    } limit_reason_e;

    typedef enum logic [1:0] {
        MOVE_HOLD,
        MOVE_UP,
        MOVE_DOWN
    } step_dir_e;

    function automatic limit_reason_e pick_reason(input logic cur, input logic st, input logic lt);
        if (cur)     return RSN_CUR;
        else if (st) return RSN_ST;
        else if (lt) return RSN_LT;
        return RSN_NONE;
    endfunction

endpackage

// File: rtl/pgov_regs.sv
module pgov_regs
    import pgov_pkg::*;
#(
    parameter int unsigned DW    = 16,
    parameter int unsigned IW    = 16,
    parameter int unsigned SW    = 4,
    parameter int unsigned KW    = 4,
    parameter int unsigned GUAR  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en_i,
    input  logic [REG_AW-1:0] wr_addr_i,
    input  logic [DW-1:0]     wr_data_i,
    output logic [DW-1:0]     lt_lim_o,
    output logic [KW-1:0]     win_k_o,
    output logic [DW-1:0]     st_lim_o,
    output logic [IW-1:0]     icc_max_o,
    output gov_ctrl_t         ctrl_o,
    output logic [SW-1:0]     req_o,
    output logic [2:0]        stat_clr_o
);

    logic [DW-1:0] lt_lim_q, st_lim_q;
    logic [KW-1:0] win_k_q;
    logic [IW-1:0] icc_max_q;
    gov_ctrl_t     ctrl_q;
    logic [SW-1:0] req_q;
    logic          locked;

    assign locked = ctrl_q.lock;

    always_ff @(posedge clk) begin
        if (rst) begin
            lt_lim_q  <= '1;
            st_lim_q  <= '1;
            icc_max_q <= '1;
            win_k_q   <= '0;
            ctrl_q    <= '0;
            req_q     <= SW'(GUAR);
        end else if (wr_en_i) begin
            case (reg_addr_e'(wr_addr_i))
                A_LT_LIM:  if (!locked) lt_lim_q  <= wr_data_i;
                A_WIN:     if (!locked) win_k_q   <= wr_data_i[KW-1:0];
                A_ST_LIM:  if (!locked) st_lim_q  <= wr_data_i;
                A_ICC_MAX: if (!locked) icc_max_q <= wr_data_i[IW-1:0];
                A_CTRL:    if (!locked) ctrl_q    <= gov_ctrl_t'(wr_data_i[CTRL_W-1:0]);
                A_REQ:     req_q <= wr_data_i[SW-1:0];
                default:   ;
            endcase
        end
    end

    assign stat_clr_o = (wr_en_i && reg_addr_e'(wr_addr_i) == A_STAT_CLR) ? wr_data_i[2:0] : 3'b000;

    assign lt_lim_o  = lt_lim_q;
    assign win_k_o   = win_k_q;
    assign st_lim_o  = st_lim_q;
    assign icc_max_o = icc_max_q;
    assign ctrl_o    = ctrl_q;
    assign req_o     = req_q;

    AST_LOCK_HOLD: assert property (@(posedge clk) disable iff (rst)
        locked |=> $stable(lt_lim_q) && $stable(st_lim_q) && $stable(icc_max_q) && $stable(win_k_q) && $stable(ctrl_q)); // R9

    AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (rst)
        locked |=> ctrl_q.lock); // R9

endmodule

// File: rtl/pgov_ewma.sv
module pgov_ewma #(
    parameter int unsigned PW   = 16,
    parameter int unsigned FRAC = 8,
    parameter int unsigned KW   = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick_i,
    input  logic [PW-1:0] pwr_i,
    input  logic [KW-1:0] win_k_i,
    output logic [PW-1:0] avg_int_o
);

    localparam int unsigned AW = PW + FRAC;

    logic [AW-1:0]        avg_q, avg_d;
    logic signed [AW:0]   diff, step;

    always_comb begin
        diff  = $signed({1'b0, pwr_i, {FRAC{1'b0}}}) - $signed({1'b0, avg_q});
        step  = diff >>> win_k_i;
        avg_d = AW'($unsigned({1'b0, avg_q}) + $unsigned(step));
    end

    always_ff @(posedge clk) begin
        if (rst)         avg_q <= '0;
        else if (tick_i) avg_q <= avg_d;
    end

    assign avg_int_o = avg_d[AW-1:FRAC];

    AST_AVG_HOLD: assert property (@(posedge clk) disable iff (rst)
        !tick_i |=> $stable(avg_q)); // R6

    AST_AVG_TRACK: assert property (@(posedge clk) disable iff (rst)
        (tick_i && win_k_i == '0) |=> avg_q == {$past(pwr_i), {FRAC{1'b0}}}); // R6

endmodule

// File: rtl/pgov_step.sv
module pgov_step
    import pgov_pkg::*;
#(
    parameter int unsigned PW     = 16,
    parameter int unsigned IW     = 16,
    parameter int unsigned SW     = 4,
    parameter int unsigned ST_MIN = 1,
    parameter int unsigned ST_GUAR = 8,
    parameter int unsigned ST_MAX = 15
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick_i,
    input  logic [PW-1:0] pwr_i,
    input  logic [IW-1:0] icc_i,
    input  logic [PW-1:0] avg_int_i,
    input  logic [PW-1:0] lt_lim_i,
    input  logic [PW-1:0] st_lim_i,
    input  logic [IW-1:0] icc_max_i,
    input  logic          lt_en_i,
    input  logic          st_en_i,
    input  logic          clamp_i,
    input  logic          turbo_i,
    input  logic [SW-1:0] req_i,
    input  logic [2:0]    clr_i,
    output logic [SW-1:0] state_o,
    output logic [2:0]    reason_o,
    output logic [2:0]    status_o
);

    localparam logic [SW-1:0] S_MIN  = SW'(ST_MIN);
    localparam logic [SW-1:0] S_GUAR = SW'(ST_GUAR);
    localparam logic [SW-1:0] S_MAX  = SW'(ST_MAX);

    logic [SW-1:0]  state_q, state_d, target, lt_floor;
    limit_reason_e  reason_q, reason_d;
    logic [2:0]     status_q;
    logic           cur_viol, st_viol, lt_viol;
    step_dir_e      dir;

    assign cur_viol = icc_i > icc_max_i;
    assign st_viol  = st_en_i && (pwr_i > st_lim_i);
    assign lt_viol  = lt_en_i && (avg_int_i > lt_lim_i);
    assign lt_floor = clamp_i ? S_MIN : S_GUAR;
    assign reason_d = pick_reason(cur_viol, st_viol, lt_viol);

    always_comb begin
        if (turbo_i)             target = S_MAX;
        else if (req_i > S_GUAR) target = S_GUAR;
        else if (req_i < S_MIN)  target = S_MIN;
        else                     target = req_i;
    end

    always_comb begin
        dir = MOVE_HOLD;
        if (cur_viol || st_viol) begin
            if (state_q > S_MIN) dir = MOVE_DOWN;
        end else if (lt_viol) begin
            if (state_q > lt_floor) dir = MOVE_DOWN;
        end else if (state_q < target) begin
            dir = MOVE_UP;
        end else if (state_q > target) begin
            dir = MOVE_DOWN;
        end
    end

    always_comb begin
        case (dir)
            MOVE_UP:   state_d = state_q + 1'b1;
            MOVE_DOWN: state_d = state_q - 1'b1;
            default:   state_d = state_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= S_MIN;
            reason_q <= RSN_NONE;
            status_q <= '0;
        end else begin
            if (tick_i) begin
                state_q  <= state_d;
                reason_q <= reason_d;
            end
            status_q <= (status_q & ~clr_i) | (tick_i ? 3'(reason_d) : 3'b000);
        end
    end

    assign state_o  = state_q;
    assign reason_o = 3'(reason_q);
    assign status_o = status_q;

    AST_STATE_RANGE: assert property (@(posedge clk) disable iff (rst)
        state_q >= S_MIN && state_q <= S_MAX); // R2

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !tick_i |=> $stable(state_q)); // R2

    AST_ONE_STEP: assert property (@(posedge clk) disable iff (rst)
        tick_i |=> (state_q == $past(state_q) || state_q == $past(state_q) + 1'b1 || state_q == $past(state_q) - 1'b1)); // R2

    AST_CUR_DOWN: assert property (@(posedge clk) disable iff (rst)
        (tick_i && cur_viol && state_q > S_MIN) |=> (state_q == $past(state_q) - 1'b1) && reason_o == 3'b100); // R4

    AST_REASON_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(reason_o)); // R4

    AST_CLAMP_FLOOR: assert property (@(posedge clk) disable iff (rst)
        (tick_i && lt_viol && !cur_viol && !st_viol && !clamp_i) |=> (state_q >= S_GUAR || state_q == $past(state_q))); // R7

endmodule

// File: rtl/pkg_pwr_gov.sv
module pkg_pwr_gov
    import pgov_pkg::*;
#(
    parameter int unsigned PW      = 16,
    parameter int unsigned IW      = 16,
    parameter int unsigned SW      = 4,
    parameter int unsigned KW      = 4,
    parameter int unsigned FRAC    = 8,
    parameter int unsigned ST_MIN  = 1,
    parameter int unsigned ST_GUAR = 8,
    parameter int unsigned ST_MAX  = 15
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_i,
    input  logic [PW-1:0]     pwr_i,
    input  logic [IW-1:0]     icc_i,
    input  logic              wr_en_i,
    input  logic [REG_AW-1:0] wr_addr_i,
    input  logic [PW-1:0]     wr_data_i,
    output logic [SW-1:0]     pstate_o,
    output logic [2:0]        reason_o,
    output logic [2:0]        status_o
);

    logic [PW-1:0] lt_lim, st_lim, avg_int;
    logic [KW-1:0] win_k;
    logic [IW-1:0] icc_max;
    gov_ctrl_t     ctrl;
    logic [SW-1:0] req;
    logic [2:0]    stat_clr;

    pgov_regs #(.DW(PW), .IW(IW), .SW(SW), .KW(KW), .GUAR(ST_GUAR)) u_regs (
        .clk(clk), .rst(rst),
        .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
        .lt_lim_o(lt_lim), .win_k_o(win_k), .st_lim_o(st_lim), .icc_max_o(icc_max),
        .ctrl_o(ctrl), .req_o(req), .stat_clr_o(stat_clr)
    );

    pgov_ewma #(.PW(PW), .FRAC(FRAC), .KW(KW)) u_ewma (
        .clk(clk), .rst(rst), .tick_i(tick_i), .pwr_i(pwr_i),
        .win_k_i(win_k), .avg_int_o(avg_int)
    );

    pgov_step #(.PW(PW), .IW(IW), .SW(SW), .ST_MIN(ST_MIN), .ST_GUAR(ST_GUAR), .ST_MAX(ST_MAX)) u_step (
        .clk(clk), .rst(rst), .tick_i(tick_i),
        .pwr_i(pwr_i), .icc_i(icc_i), .avg_int_i(avg_int),
        .lt_lim_i(lt_lim), .st_lim_i(st_lim), .icc_max_i(icc_max),
        .lt_en_i(ctrl.lt_en), .st_en_i(ctrl.st_en), .clamp_i(ctrl.lt_clamp), .turbo_i(ctrl.turbo_en),
        .req_i(req), .clr_i(stat_clr),
        .state_o(pstate_o), .reason_o(reason_o), .status_o(status_o)
    );

endmodule

// File: tb/pkg_pwr_gov_tb_top.sv
`timescale 1ns/1ps
module pkg_pwr_gov_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick = 1'b0;
    logic [15:0] pwr = '0;
    logic [15:0] icc = '0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [3:0]  pstate;
    logic [2:0]  reason, status;

    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    pkg_pwr_gov dut_i (
        .clk(clk), .rst(rst), .tick_i(tick), .pwr_i(pwr), .icc_i(icc),
        .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
        .pstate_o(pstate), .reason_o(reason), .status_o(status)
    );

    // power, current, expected state, expected reason (entry state 14, k=0)
    localparam int VEC[10][4] = '{
        '{ 50,  50, 15, 0},
        '{ 50,  50, 15, 0},
        '{120,  50, 14, 1},
        '{120,  50, 13, 1},
        '{200,  50, 12, 2},
        '{200, 250, 11, 4},
        '{ 50, 250, 10, 4},
        '{ 50,  50, 11, 0},
        '{100, 200, 12, 0},
        '{150,  50, 11, 1}
    };

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 3'(a); wr_data = 16'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_tick(input int p, input int i);
        @(negedge clk);
        pwr = 16'(p); icc = 16'(i); tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
    endtask

    initial begin
        #2_000_000;
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        do_reset();
        chk("R1 reset state", pstate, 1);
        chk("R1 reset reason", reason, 0);
        chk("R1 reset status", status, 0);
        repeat (4) @(negedge clk);
        chk("R2 no tick hold", pstate, 1);

        wr(0, 100); wr(1, 0); wr(2, 150); wr(3, 200); wr(4, 19);
        for (int n = 0; n < 13; n++) begin
            do_tick(50, 50);
            chk("R2 rise", pstate, 2 + n);
        end

        for (int v = 0; v < 10; v++) begin
            do_tick(VEC[v][0], VEC[v][1]);
            chk("R2 R4 R5 R6 table state", pstate, VEC[v][2]);
            chk("R4 R5 R6 table reason", reason, VEC[v][3]);
        end

        chk("R10 sticky status", status, 7);
        wr(6, 1);
        chk("R10 clear bit0", status, 6);

        for (int n = 0; n < 4; n++) do_tick(120, 50);
        chk("R7 unclamped floor", pstate, 8);
        chk("R7 unclamped reason", reason, 1);
        wr(4, 23);
        do_tick(120, 50);
        chk("R7 clamped below guaranteed", pstate, 7);

        wr(4, 18);
        do_tick(120, 50);
        chk("R8 long-term disabled state", pstate, 8);
        chk("R8 long-term disabled reason", reason, 0);

        wr(4, 23);
        for (int n = 0; n < 8; n++) do_tick(0, 250);
        chk("R4 current floor", pstate, 1);
        chk("R4 current reason", reason, 4);

        wr(4, 3); wr(5, 12);
        for (int n = 0; n < 9; n++) do_tick(50, 50);
        chk("R3 request clipped to guaranteed", pstate, 8);
        wr(5, 3);
        for (int n = 0; n < 6; n++) do_tick(50, 50);
        chk("R3 step down to request", pstate, 3);

        wr(4, 11);
        wr(0, 500);
        wr(4, 16);
        wr(5, 12);
        do_tick(120, 50);
        chk("R9 locked limit kept", reason, 1);
        chk("R9 locked state hold", pstate, 3);
        for (int n = 0; n < 6; n++) do_tick(50, 50);
        chk("R9 locked ctrl, request accepted", pstate, 8);

        do_reset();
        chk("R1 R10 status after reset", status, 0);
        wr(0, 100); wr(1, 2); wr(3, 200); wr(4, 17);
        for (int n = 0; n < 10; n++) do_tick(0, 50);
        chk("R6 idle rise", pstate, 11);
        // k=2, sample 160: averages 40, 70, 92.5, 109.375
        do_tick(160, 50); chk("R6 burst t1 state", pstate, 12); chk("R6 burst t1 reason", reason, 0);
        do_tick(160, 50); chk("R6 burst t2 state", pstate, 13);
        do_tick(160, 50); chk("R6 burst t3 state", pstate, 14); chk("R6 burst t3 reason", reason, 0);
        do_tick(160, 50); chk("R6 burst t4 state", pstate, 13); chk("R6 burst t4 reason", reason, 1);
        for (int n = 0; n < 30; n++) do_tick(160, 50);
        chk("R6 R7 sustained settle", pstate, 8);
        // average near 159.98, then 119.99 (still over), then 89.99
        do_tick(0, 50);
        chk("R6 decay t1 state", pstate, 8);
        chk("R6 decay t1 reason", reason, 1);
        do_tick(0, 50);
        chk("R6 decay t2 state", pstate, 9);
        chk("R6 decay t2 reason", reason, 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule